// File: doc/BRIEF.md
# Dual-Port RAM Collision Arbiter

This block is a synchronous true dual-port memory with a left and a right port. Each port can read or write any word on any cycle. When both ports are enabled on the same address in the same cycle, an arbiter lets one side through and pulls the other side's active-low busy line. A write from the side that loses is dropped inside the block. Whether each access is a read or a write plays no part in that decision; only the enables and the addresses count.

A mode input selects the role of the device. As master it runs the arbiter and drives both busy outputs. As slave the arbiter is switched off and the two busy inputs act only as per-port write inhibits. To build a wider word, one master device makes the decision and every slave in the same address range takes its busy inputs from the master's busy outputs, so all byte lanes lose on the same side. The arbiter is a three-state machine: `ARB_FREE` (no collision on the previous cycle), `ARB_LEFT_HELD` (left won the previous cycle's collision) and `ARB_RIGHT_HELD` (right won it). The transitions are: FREE to LEFT_HELD on a fresh collision that left wins, FREE to RIGHT_HELD on a fresh collision in which right was the incumbent, HELD to the same HELD while the collision goes on, and any state to FREE on a cycle without a collision or in slave mode.

The default build is 1024 words of 8 bits, which keeps elaboration light. Setting `ADDR_W` to 14 gives the 16384-word organisation.

Top module: `dpr_collision_ram`

## Requirements
- R1: The memory holds 2**ADDR_W words of DATA_W bits. An enabled access on a port puts the word stored at its address on that port's read data one cycle later, with the value from before any write in that same cycle. A port that is not enabled keeps its read data unchanged.
- R2: In master mode a collision is declared exactly when both enables are high and both addresses are equal. The write strobes play no part in this.
- R3: Busy is active low (0 means busy). On a collision in master mode exactly one of the two busy outputs is 0. With no collision both are 1.
- R4: A busy output is never 0 for a port whose enable is low. In slave mode both busy outputs stay at 1.
- R5: In master mode a write from the losing port leaves the memory unchanged. A read from the losing port still returns the stored word, which is the value before any write by the winner in that cycle.
- R6: On a collision whose previous cycle had no collision, the left port wins. The exception is when the right port was enabled at that same address on the previous cycle and the left port was not: then the right port wins.
- R7: While a collision continues on consecutive cycles, the port that won on the first of those cycles keeps winning. A cycle without a collision returns the arbiter to `ARB_FREE`.
- R8: In slave mode the arbiter suppresses no write. A port whose busy input is 0 cannot write. A port whose busy input is 1 writes normally.
- R9: In slave mode, if both ports write the same address in one cycle without inhibit, the left port's data is stored.
- R10: During reset both read data outputs are 0 and the arbiter is in `ARB_FREE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1 = master (arbiter drives busy), 0 = slave (busy inputs inhibit writes) |
| l_en | input | 1 | Left port enable |
| l_we | input | 1 | Left port write strobe (1 = write) |
| l_addr | input | ADDR_W | Left port address |
| l_wdata | input | DATA_W | Left port write data |
| l_rdata | output | DATA_W | Left port read data, one cycle after the access |
| l_busy_n_o | output | 1 | Left busy from the arbiter, active low |
| l_busy_n_i | input | 1 | Left write inhibit in slave mode, active low |
| r_en | input | 1 | Right port enable |
| r_we | input | 1 | Right port write strobe (1 = write) |
| r_addr | input | ADDR_W | Right port address |
| r_wdata | input | DATA_W | Right port write data |
| r_rdata | output | DATA_W | Right port read data, one cycle after the access |
| r_busy_n_o | output | 1 | Right busy from the arbiter, active low |
| r_busy_n_i | input | 1 | Right write inhibit in slave mode, active low |

## Verification
The hardest case to reach from the ports is a collision that the right port wins. That needs a cycle where the right port alone sits on an address, followed by a cycle where the left port joins it, and then the collision has to be held for several cycles to exercise the sticky winner. The stimulus builds this in a directed phase: right reads address A, then both ports write A for three cycles, and a free cycle follows. A long stress phase then confines both ports to four addresses and toggles the mode now and then. A reference model compares busy and read data on every cycle.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    typedef enum logic [1:0] {
        ARB_FREE       = 2'd0,
        ARB_LEFT_HELD  = 2'd1,
        ARB_RIGHT_HELD = 2'd2
    } arb_state_t;

    localparam int PORT_L = 0;
    localparam int PORT_R = 1;
    localparam int NUM_PORTS = 2;
endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              coll,
    output logic              l_lose,
    output logic              r_lose
);
    arb_state_t        state_q, state_d;
    logic              l_en_q, r_en_q;
    logic [ADDR_W-1:0] l_addr_q, r_addr_q;
    logic              l_inc, r_inc, pick_left;
    logic              past_ok;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ARB_FREE;
            l_en_q   <= 1'b0;
            r_en_q   <= 1'b0;
            l_addr_q <= '0;
            r_addr_q <= '0;
            past_ok  <= 1'b0;
        end else begin
            state_q  <= state_d;
            l_en_q   <= l_en;
            r_en_q   <= r_en;
            l_addr_q <= l_addr;
            r_addr_q <= r_addr;
            past_ok  <= 1'b1;
        end
    end

    // decision and next state
    always_comb begin
        coll  = master & l_en & r_en & (l_addr == r_addr);
        l_inc = l_en_q & (l_addr_q == l_addr);
        r_inc = r_en_q & (r_addr_q == r_addr);
        unique case (state_q)
            ARB_LEFT_HELD:  pick_left = 1'b1;
            ARB_RIGHT_HELD: pick_left = 1'b0;
            ARB_FREE:       pick_left = !(r_inc & !l_inc);
            default:        pick_left = 1'b1;
        endcase
        if (!coll)          state_d = ARB_FREE;
        else if (pick_left) state_d = ARB_LEFT_HELD;
        else                state_d = ARB_RIGHT_HELD;
        l_lose = coll & !pick_left;
        r_lose = coll & pick_left;
    end

    a_r3_one_loser: assert property (@(posedge clk) disable iff (!rst_n)
        coll |-> ($countones({l_lose, r_lose}) == 1));
    a_r7_sticky_left: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(r_lose) && coll) |-> r_lose);
    a_r7_sticky_right: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(l_lose) && coll) |-> l_lose);
    a_r6_fresh_left: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && coll && !$past(r_en)) |-> r_lose);
    a_r2_no_coll_no_loser: assert property (@(posedge clk) disable iff (!rst_n)
        !coll |-> (!l_lose && !r_lose));
endmodule

// File: rtl/dpr_busy_ctrl.sv
module dpr_busy_ctrl
    import dpr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 master,
    input  logic [NUM_PORTS-1:0] en,
    input  logic [NUM_PORTS-1:0] lose,
    input  logic [NUM_PORTS-1:0] busy_n_i,
    output logic [NUM_PORTS-1:0] busy_n_o,
    output logic [NUM_PORTS-1:0] block
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        always_comb begin
            if (master) begin
                busy_n_o[p] = !lose[p];
                block[p]    = lose[p];
            end else begin
                busy_n_o[p] = 1'b1;
                block[p]    = !busy_n_i[p];
            end
        end

        a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !en[p] |-> busy_n_o[p]);
        a_r4_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !master |-> busy_n_o[p]);
        a_r5_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
            (master && !busy_n_o[p]) |-> block[p]);
    end

    a_r3_not_both_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_n_o == '0));
endmodule

// File: rtl/dpr_mem_core.sv
module dpr_mem_core
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_PORTS-1:0]              en,
    input  logic [NUM_PORTS-1:0]              we,
    input  logic [NUM_PORTS-1:0]              block,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  addr,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]  wdata,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0]    mem [DEPTH];
    logic [NUM_PORTS-1:0] wr_ok;

    always_comb wr_ok = en & we & ~block;

    // right is written first so that left lands last on a shared address
    always_ff @(posedge clk) begin
        if (wr_ok[PORT_R]) mem[addr[PORT_R]] <= wdata[PORT_R];
        if (wr_ok[PORT_L]) mem[addr[PORT_L]] <= wdata[PORT_L];
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
        always_ff @(posedge clk) begin
            if (!rst_n)     rdata[p] <= '0;
            else if (en[p]) rdata[p] <= mem[addr[p]];
        end

        a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !en[p] |=> $stable(rdata[p]));
    end
endmodule

// File: rtl/dpr_collision_ram.sv
module dpr_collision_ram
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              l_en,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_busy_n_o,
    input  logic              l_busy_n_i,
    input  logic              r_en,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_busy_n_o,
    input  logic              r_busy_n_i
);
    logic                             coll, l_lose, r_lose;
    logic [NUM_PORTS-1:0]             en_v, we_v, lose_v, bin_v, bout_v, blk_v;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v;
    logic [NUM_PORTS-1:0][DATA_W-1:0] wd_v, rd_v;

    always_comb begin
        en_v   = {r_en, l_en};
        we_v   = {r_we, l_we};
        lose_v = {r_lose, l_lose};
        bin_v  = {r_busy_n_i, l_busy_n_i};
        addr_v = {r_addr, l_addr};
        wd_v   = {r_wdata, l_wdata};
    end

    dpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .master(master_mode),
        .l_en(l_en), .l_addr(l_addr), .r_en(r_en), .r_addr(r_addr),
        .coll(coll), .l_lose(l_lose), .r_lose(r_lose)
    );

    dpr_busy_ctrl u_busy (
        .clk(clk), .rst_n(rst_n), .master(master_mode),
        .en(en_v), .lose(lose_v), .busy_n_i(bin_v),
        .busy_n_o(bout_v), .block(blk_v)
    );

    dpr_mem_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .en(en_v), .we(we_v), .block(blk_v),
        .addr(addr_v), .wdata(wd_v), .rdata(rd_v)
    );

    always_comb begin
        l_rdata    = rd_v[PORT_L];
        r_rdata    = rd_v[PORT_R];
        l_busy_n_o = bout_v[PORT_L];
        r_busy_n_o = bout_v[PORT_R];
    end

    a_r2_coll_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && l_en && r_en && l_addr == r_addr) |-> (l_busy_n_o != r_busy_n_o));
    a_r10_reset_rdata: assert property (@(posedge clk)
        $past(!rst_n) |-> (l_rdata == '0 && r_rdata == '0));
endmodule

// File: tb/tb_dpr_collision_ram.sv
module tb_dpr_collision_ram;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n;
    logic master_mode;
    logic l_en, l_we, l_busy_n_i, r_en, r_we, r_busy_n_i;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata;
    logic [DW-1:0] l_rdata, r_rdata;
    logic l_busy_n_o, r_busy_n_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpr_collision_ram #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    // reference model state
    logic [DW-1:0] ref_mem [DEPTH];
    logic [DW-1:0] exp_lr, exp_rr;
    int held;                     // 0 free, 1 left won, 2 right won
    logic pl_en, pr_en;
    logic [AW-1:0] pl_a, pr_a;
    bit l_lost, r_lost;

    always @(posedge clk) cyc++;

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    task automatic step(input bit m,
                        input bit le, input bit lw, input int la, input int ld,
                        input bit re, input bit rw, input int ra, input int rd,
                        input bit lbi = 1, input bit rbi = 1);
        bit coll, pick_left, lblk, rblk, l_inc, r_inc;
        logic [DW-1:0] nl, nr;
        @(negedge clk);
        master_mode = m; l_en = le; l_we = lw; l_addr = AW'(la); l_wdata = DW'(ld);
        r_en = re; r_we = rw; r_addr = AW'(ra); r_wdata = DW'(rd);
        l_busy_n_i = lbi; r_busy_n_i = rbi;
        #1;
        coll  = m && le && re && (la == ra);
        l_inc = pl_en && (pl_a == AW'(la));
        r_inc = pr_en && (pr_a == AW'(ra));
        if (held == 1)      pick_left = 1;
        else if (held == 2) pick_left = 0;
        else                pick_left = !(r_inc && !l_inc);
        // R2 R3 R4: busy levels
        check(!m ? "R4 slave busy" : (!le ? "R4 idle busy" : "R3 left busy"),
              l_busy_n_o, !(coll && !pick_left));
        check(!m ? "R4 slave busy" : (!re ? "R4 idle busy" : "R3 right busy"),
              r_busy_n_o, !(coll && pick_left));
        lblk = m ? (coll && !pick_left) : !lbi;
        rblk = m ? (coll && pick_left)  : !rbi;
        l_lost = coll && !pick_left;
        r_lost = coll && pick_left;
        nl = ref_mem[la];
        nr = ref_mem[ra];
        if (re && rw && !rblk) ref_mem[ra] = DW'(rd);
        if (le && lw && !lblk) ref_mem[la] = DW'(ld);   // R9 left lands last
        if (le) exp_lr = nl;
        if (re) exp_rr = nr;
        held = !coll ? 0 : (pick_left ? 1 : 2);
        pl_en = le; pr_en = re; pl_a = AW'(la); pr_a = AW'(ra);
        @(posedge clk); #1;
        check(l_lost ? "R5 left loser read" : "R1 left read", l_rdata, exp_lr);
        check(r_lost ? "R5 right loser read" : "R1 right read", r_rdata, exp_rr);
    endtask

    initial begin
        int lim;
        lim = 100000;
        wait (cyc > lim || done);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected below %0d", cyc, lim);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        master_mode = 1; l_en = 0; l_we = 0; l_addr = '0; l_wdata = '0;
        r_en = 0; r_we = 0; r_addr = '0; r_wdata = '0;
        l_busy_n_i = 1; r_busy_n_i = 1;
        held = 0; pl_en = 0; pr_en = 0; pl_a = '0; pr_a = '0;
        exp_lr = '0; exp_rr = '0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        check("R10 left rdata reset", l_rdata, 0);
        check("R10 right rdata reset", r_rdata, 0);
        check("R10 left busy idle", l_busy_n_o, 1);
        @(negedge clk); rst_n = 1;

        // R1: fill memory from both ports at distinct addresses
        for (int a = 0; a < DEPTH / 2; a++)
            step(1, 1, 1, a, (a * 7 + 3) & 8'hff, 1, 1, a + DEPTH/2, (a * 5 + 9) & 8'hff);
        for (int a = 0; a < 32; a++)
            step(1, 1, 0, a, 0, 1, 0, DEPTH - 1 - a, 0);

        // R2 R6: fresh collision, both writing: left wins, right blocked
        step(1, 1, 1, 40, 8'hA1, 1, 1, 40, 8'hB2);
        step(1, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 1, 0, 40, 0, 0, 0, 0, 0);
        check("R6 left write kept", l_rdata, 8'hA1);

        // R2 R5: collision of a right read with a left write: right reads old data
        step(1, 1, 1, 41, 8'h3C, 1, 0, 41, 0);
        step(1, 0, 0, 0, 0, 1, 0, 41, 0);
        check("R5 winner write visible", r_rdata, 8'h3C);

        // R6 R7: right incumbent at 50, left joins and both write for 3 cycles
        step(1, 0, 0, 0, 0, 1, 0, 50, 0);
        step(1, 1, 1, 50, 8'h11, 1, 1, 50, 8'h22);
        step(1, 1, 1, 50, 8'h33, 1, 1, 50, 8'h44);
        step(1, 1, 1, 50, 8'h55, 1, 1, 50, 8'h66);
        step(1, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 1, 0, 50, 0, 0, 0, 0, 0);
        check("R7 sticky right winner", l_rdata, 8'h66);
        // R7: free cycle resets; fresh collision goes left
        step(1, 1, 1, 51, 8'h77, 1, 1, 51, 8'h88);
        step(1, 0, 0, 0, 0, 1, 0, 51, 0);
        check("R7 fresh after free", r_rdata, 8'h77);

        // R8: slave mode, right inhibited, left free
        step(0, 1, 1, 60, 8'h90, 1, 1, 61, 8'h91, 1, 0);
        step(0, 1, 0, 61, 0, 1, 0, 60, 0);
        check("R8 inhibited right write", l_rdata, (((61 * 7) + 3) & 8'hff));
        check("R8 normal left write", r_rdata, 8'h90);
        // R9: slave, both write same address: left data stored
        step(0, 1, 1, 62, 8'hC4, 1, 1, 62, 8'hD5, 1, 1);
        step(0, 1, 0, 62, 0, 0, 0, 0, 0);
        check("R9 left wins slave write", l_rdata, 8'hC4);

        // stress: four addresses, random mix and occasional mode change
        for (int i = 0; i < 4000; i++) begin
            bit m;
            m = ($urandom % 8) != 0;
            step(m, bit'($urandom % 4 != 0), bit'($urandom), $urandom % 4, $urandom % 256,
                 bit'($urandom % 4 != 0), bit'($urandom), $urandom % 4, $urandom % 256,
                 bit'($urandom % 3 != 0), bit'($urandom % 3 != 0));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule